// File: doc/BRIEF.md
# Maximum Address Limit Guard

This block sits in a storage device controller, behind the command decoder. It handles two command codes. The first reports the device's native (physical) maximum address. The second either moves the user-visible maximum address or runs a small lock-management subcommand. The feature byte selects among setting a password, locking, unlocking and freezing.

A new limit is taken only when the command accepted just before it was the native-max query. It is also refused if the block is locked or frozen, or if the requested address lies above the native maximum.

A limit can be marked persistent. A persistent limit survives a hard reset, and only one persistent change is allowed between resets. A hard reset brings back the last persistent limit, or the native maximum if none was made, and returns the lock to open. Frozen can be left only by a reset.

Commands arrive on a valid/ready stream. Each handled command produces one result on a second valid/ready stream. Back-pressure rules:
- A result stays on the output, unchanged, until `rsp_ready` is seen high.
- `cmd_ready` is low while a result is waiting and while `hard_rst` is high.
- Commands with other codes are accepted but produce no result.

Top module: `maxaddr_guard`

## Requirements
- R1: After `rst_n` is released, `max_addr` equals the native maximum, `lock_state` is 0 (open), `rsp_valid` is 0 and `cmd_ready` is 1.
- R2: Command code F8h always completes, in any lock condition, with status 50h, error 00h and `rsp_addr` equal to the native maximum.
- R3: Command code F9h with feature 00h (set limit) is aborted with status 51h and error 04h unless the command accepted immediately before it was F8h.
- R4: An accepted set limit completes with status 50h and error 00h. From the same cycle as the result, `max_addr` and `rsp_addr` hold the requested address. `max_addr` changes at no other time except a hard reset.
- R5: A command with a code other than F8h or F9h gives no result and leaves `max_addr` and `lock_state` unchanged. It still counts as the preceding command, so a following set limit is aborted.
- R6: A set limit with `cmd_keep` = 1 (persistent) is accepted at most once between resets. A later persistent request is aborted even when it follows F8h. A non-persistent request is still accepted.
- R7: When `hard_rst` is high, the next edge does the following:
  - sets `lock_state` to 0 and drops any pending result;
  - loads `max_addr` with the last accepted persistent limit, or the native maximum if there is none;
  - restores the one-time persistent allowance;
  - forgets the preceding F8h.
- R8: A set limit whose address is above the native maximum is aborted with 51h/04h. `max_addr` never exceeds the native maximum.
- R9: In the locked (1) or frozen (2) condition, a set limit is aborted with 51h/04h.
- R10: F9h subcommands behave as follows:
  - feature 01h stores `cmd_pw` as the password (open only);
  - feature 02h moves open to locked;
  - feature 03h moves locked to open, only when `cmd_pw` equals the stored password.
  - Each completes with 50h/00h; otherwise it is aborted with 51h/04h.
- R11: F9h with feature 04h moves open or locked to frozen. In frozen, every F9h is aborted, and only `hard_rst` or `rst_n` leaves it. F9h with any feature above 04h is aborted.
- R12: For every F9h result, `rsp_addr` equals `max_addr` after that command. Aborted results always carry 51h/04h and successful ones 50h/00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| hard_rst | input | 1 | Hard reset indication, synchronous, one or more cycles |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted this cycle when high with `cmd_valid` |
| cmd_code | input | 8 | Decoded command code |
| cmd_feature | input | 8 | Feature byte, subcommand select for F9h |
| cmd_addr | input | ADDR_W | Requested maximum address |
| cmd_keep | input | 1 | 1 = requested limit persists across hard reset |
| cmd_pw | input | PW_W | Password for set-password and unlock |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result taken this cycle when high with `rsp_valid` |
| rsp_status | output | 8 | Completion status byte |
| rsp_error | output | 8 | Completion error byte |
| rsp_addr | output | ADDR_W | Native maximum (F8h) or limit after the command (F9h) |
| max_addr | output | ADDR_W | Current user-visible maximum address |
| lock_state | output | 2 | 0 open, 1 locked, 2 frozen |

## Verification
The assertions assume the environment behaves as follows:
- `cmd_valid` is taken only while `cmd_ready` is high.
- The command fields hold steady for the accepting edge.
- `hard_rst` is never raised while a command is being handed over without the block refusing it.

The stimulus keeps within these limits. It drives commands at falling edges only after seeing `cmd_ready` high, and drops `cmd_valid` right after the accepting edge. It issues hard resets only when no result is pending and the expected queue is empty. `rsp_ready` follows an irregular pattern, so results are held over several cycles and the stability rules are exercised.

// File: rtl/maxaddr_guard_pkg.sv
package maxaddr_guard_pkg;

  typedef enum logic [1:0] {
    LK_OPEN   = 2'd0,
    LK_HELD   = 2'd1,
    LK_FROZEN = 2'd2
  } lock_e;

  localparam logic [7:0] CODE_READ_NATIVE = 8'hF8;
  localparam logic [7:0] CODE_SET_MAX     = 8'hF9;

  localparam logic [7:0] SUB_ADDR   = 8'h00;
  localparam logic [7:0] SUB_PW     = 8'h01;
  localparam logic [7:0] SUB_LOCK   = 8'h02;
  localparam logic [7:0] SUB_UNLOCK = 8'h03;
  localparam logic [7:0] SUB_FREEZE = 8'h04;

  localparam logic [7:0] ST_DONE  = 8'h50;
  localparam logic [7:0] ST_ABORT = 8'h51;
  localparam logic [7:0] ER_NONE  = 8'h00;
  localparam logic [7:0] ER_ABORT = 8'h04;

endpackage

// File: rtl/maxaddr_guard_judge.sv
module maxaddr_guard_judge
  import maxaddr_guard_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int PW_W   = 16,
  parameter logic [ADDR_W-1:0] NATIVE_MAX = '1
) (
  input  logic [7:0]        code,
  input  logic [7:0]        feature,
  input  logic [ADDR_W-1:0] addr,
  input  logic              keep,
  input  logic [PW_W-1:0]   pw,
  input  lock_e             lock_q,
  input  logic              prev_rn_q,
  input  logic              keep_used_q,
  input  logic [PW_W-1:0]   pw_q,
  output logic              respond,
  output logic              ok,
  output logic              is_read,
  output logic              do_addr,
  output logic              do_keep,
  output logic              do_pw,
  output lock_e             lock_nxt
);

  logic open_c;
  logic addr_fits;
  logic keep_allowed;

  assign open_c       = (lock_q == LK_OPEN);
  assign addr_fits    = (addr <= NATIVE_MAX);
  assign keep_allowed = !(keep && keep_used_q);

  always_comb begin
    respond  = 1'b0;
    ok       = 1'b0;
    is_read  = 1'b0;
    do_addr  = 1'b0;
    do_keep  = 1'b0;
    do_pw    = 1'b0;
    lock_nxt = lock_q;
    if (code == CODE_READ_NATIVE) begin
      respond = 1'b1;
      ok      = 1'b1;
      is_read = 1'b1;
    end else if (code == CODE_SET_MAX) begin
      respond = 1'b1;
      case (feature)
        SUB_ADDR: begin
          if (open_c && prev_rn_q && addr_fits && keep_allowed) begin
            ok      = 1'b1;
            do_addr = 1'b1;
            do_keep = keep;
          end
        end
        SUB_PW: begin
          if (open_c) begin
            ok    = 1'b1;
            do_pw = 1'b1;
          end
        end
        SUB_LOCK: begin
          if (open_c) begin
            ok       = 1'b1;
            lock_nxt = LK_HELD;
          end
        end
        SUB_UNLOCK: begin
          if (lock_q == LK_HELD && pw == pw_q) begin
            ok       = 1'b1;
            lock_nxt = LK_OPEN;
          end
        end
        SUB_FREEZE: begin
          if (lock_q != LK_FROZEN) begin
            ok       = 1'b1;
            lock_nxt = LK_FROZEN;
          end
        end
        default: ok = 1'b0;
      endcase
    end
  end

  // R11
  always_comb begin
    frozen_abort_chk: assert (!(lock_q == LK_FROZEN && code == CODE_SET_MAX && ok));
  end

endmodule

// File: rtl/maxaddr_guard_state.sv
module maxaddr_guard_state
  import maxaddr_guard_pkg::*;
#(
  parameter int PW_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hard_rst,
  input  logic            fire,
  input  logic            is_read,
  input  logic            ok,
  input  logic            do_keep,
  input  logic            do_pw,
  input  logic [PW_W-1:0] pw_in,
  input  lock_e           lock_nxt,
  output lock_e           lock_q,
  output logic            prev_rn_q,
  output logic            keep_used_q,
  output logic [PW_W-1:0] pw_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q      <= LK_OPEN;
      prev_rn_q   <= 1'b0;
      keep_used_q <= 1'b0;
      pw_q        <= '0;
    end else if (hard_rst) begin
      lock_q      <= LK_OPEN;
      prev_rn_q   <= 1'b0;
      keep_used_q <= 1'b0;
    end else if (fire) begin
      prev_rn_q <= is_read;
      if (ok) begin
        lock_q <= lock_nxt;
        if (do_keep) keep_used_q <= 1'b1;
        if (do_pw)   pw_q        <= pw_in;
      end
    end
  end

  // R11
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q == LK_FROZEN && !hard_rst) |=> (lock_q == LK_FROZEN));

  // R6
  keep_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (keep_used_q && !hard_rst) |=> keep_used_q);

  // R7
  hard_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hard_rst |=> (lock_q == LK_OPEN && !prev_rn_q && !keep_used_q));

endmodule

// File: rtl/maxaddr_guard_limit.sv
module maxaddr_guard_limit #(
  parameter int ADDR_W = 28,
  parameter logic [ADDR_W-1:0] NATIVE_MAX = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hard_rst,
  input  logic              apply,
  input  logic              keep,
  input  logic [ADDR_W-1:0] new_addr,
  output logic [ADDR_W-1:0] max_q
);

  logic [ADDR_W-1:0] saved_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      max_q   <= NATIVE_MAX;
      saved_q <= NATIVE_MAX;
    end else if (hard_rst) begin
      max_q <= saved_q;
    end else if (apply) begin
      max_q <= new_addr;
      if (keep) saved_q <= new_addr;
    end
  end

  // R8
  under_native_chk: assert property (@(posedge clk) disable iff (!rst_n)
    max_q <= NATIVE_MAX);

  // R4
  limit_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!apply && !hard_rst) |=> $stable(max_q));

endmodule

// File: rtl/maxaddr_guard_resp.sv
module maxaddr_guard_resp
  import maxaddr_guard_pkg::*;
#(
  parameter int ADDR_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hard_rst,
  input  logic              load,
  input  logic              ok,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [7:0]        rsp_status,
  output logic [7:0]        rsp_error,
  output logic [ADDR_W-1:0] rsp_addr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_status <= ST_DONE;
      rsp_error  <= ER_NONE;
      rsp_addr   <= '0;
    end else if (hard_rst) begin
      rsp_valid <= 1'b0;
    end else if (load) begin
      rsp_valid  <= 1'b1;
      rsp_status <= ok ? ST_DONE : ST_ABORT;
      rsp_error  <= ok ? ER_NONE : ER_ABORT;
      rsp_addr   <= addr_in;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R12
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready && !hard_rst) |=>
      (rsp_valid && $stable(rsp_status) && $stable(rsp_error) && $stable(rsp_addr)));

  // R12
  status_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_status == ST_DONE && rsp_error == ER_NONE) ||
                   (rsp_status == ST_ABORT && rsp_error == ER_ABORT)));

endmodule

// File: rtl/maxaddr_guard.sv
module maxaddr_guard
  import maxaddr_guard_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int PW_W   = 16,
  parameter logic [ADDR_W-1:0] NATIVE_MAX = 28'h0A0_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hard_rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [7:0]        cmd_code,
  input  logic [7:0]        cmd_feature,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_keep,
  input  logic [PW_W-1:0]   cmd_pw,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [7:0]        rsp_status,
  output logic [7:0]        rsp_error,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [ADDR_W-1:0] max_addr,
  output logic [1:0]        lock_state
);

  lock_e             lock_q;
  lock_e             lock_nxt;
  logic              prev_rn_q;
  logic              keep_used_q;
  logic [PW_W-1:0]   pw_q;
  logic              respond, ok, is_read, do_addr, do_keep, do_pw;
  logic              fire;
  logic              apply;
  logic [ADDR_W-1:0] max_q;
  logic [ADDR_W-1:0] result_addr;

  assign cmd_ready  = !rsp_valid && !hard_rst;
  assign fire       = cmd_valid && cmd_ready;
  assign apply      = fire && ok && do_addr;
  assign max_addr   = max_q;
  assign lock_state = lock_q;

  always_comb begin
    if (is_read)      result_addr = NATIVE_MAX;
    else if (do_addr) result_addr = cmd_addr;
    else              result_addr = max_q;
  end

  maxaddr_guard_judge #(
    .ADDR_W(ADDR_W), .PW_W(PW_W), .NATIVE_MAX(NATIVE_MAX)
  ) judge_i (
    .code(cmd_code), .feature(cmd_feature), .addr(cmd_addr), .keep(cmd_keep),
    .pw(cmd_pw), .lock_q(lock_q), .prev_rn_q(prev_rn_q),
    .keep_used_q(keep_used_q), .pw_q(pw_q), .respond(respond), .ok(ok),
    .is_read(is_read), .do_addr(do_addr), .do_keep(do_keep), .do_pw(do_pw),
    .lock_nxt(lock_nxt)
  );

  maxaddr_guard_state #(.PW_W(PW_W)) state_i (
    .clk(clk), .rst_n(rst_n), .hard_rst(hard_rst), .fire(fire),
    .is_read(is_read), .ok(ok), .do_keep(do_keep), .do_pw(do_pw),
    .pw_in(cmd_pw), .lock_nxt(lock_nxt), .lock_q(lock_q),
    .prev_rn_q(prev_rn_q), .keep_used_q(keep_used_q), .pw_q(pw_q)
  );

  maxaddr_guard_limit #(.ADDR_W(ADDR_W), .NATIVE_MAX(NATIVE_MAX)) limit_i (
    .clk(clk), .rst_n(rst_n), .hard_rst(hard_rst), .apply(apply),
    .keep(cmd_keep), .new_addr(cmd_addr), .max_q(max_q)
  );

  maxaddr_guard_resp #(.ADDR_W(ADDR_W)) resp_i (
    .clk(clk), .rst_n(rst_n), .hard_rst(hard_rst), .load(fire && respond),
    .ok(ok), .addr_in(result_addr), .rsp_ready(rsp_ready),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_error(rsp_error),
    .rsp_addr(rsp_addr)
  );

  // R3
  need_query_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmd_code == CODE_SET_MAX && cmd_feature == SUB_ADDR && !prev_rn_q)
      |=> (rsp_valid && rsp_status == ST_ABORT && rsp_error == ER_ABORT));

  // R9
  locked_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmd_code == CODE_SET_MAX && cmd_feature == SUB_ADDR && lock_q != LK_OPEN)
      |=> (rsp_status == ST_ABORT && $stable(max_q)));

  // R2
  native_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmd_code == CODE_READ_NATIVE)
      |=> (rsp_valid && rsp_status == ST_DONE && rsp_addr == NATIVE_MAX));

endmodule

// File: tb/maxaddr_guard_tb_top.sv
module maxaddr_guard_tb_top;

  localparam int ADDR_W = 28;
  localparam int PW_W   = 16;
  localparam logic [ADDR_W-1:0] NATIVE = 28'h0A0_0000;

  typedef struct {
    logic [7:0]        st;
    logic [7:0]        er;
    logic [ADDR_W-1:0] ad;
    logic [ADDR_W-1:0] mx;
    logic [1:0]        lk;
    string             tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hard_rst = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [7:0] cmd_code = '0;
  logic [7:0] cmd_feature = '0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic cmd_keep = 1'b0;
  logic [PW_W-1:0] cmd_pw = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic [7:0] rsp_status, rsp_error;
  logic [ADDR_W-1:0] rsp_addr, max_addr;
  logic [1:0] lock_state;

  always #4 clk = ~clk;

  maxaddr_guard #(.ADDR_W(ADDR_W), .PW_W(PW_W), .NATIVE_MAX(NATIVE)) dut_i (
    .clk(clk), .rst_n(rst_n), .hard_rst(hard_rst), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_code(cmd_code), .cmd_feature(cmd_feature),
    .cmd_addr(cmd_addr), .cmd_keep(cmd_keep), .cmd_pw(cmd_pw),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status),
    .rsp_error(rsp_error), .rsp_addr(rsp_addr), .max_addr(max_addr),
    .lock_state(lock_state)
  );

  int total = 0;
  int fails = 0;
  exp_t exp_q[$];

  // independent model
  logic [1:0]        m_lock = 2'd0;
  logic              m_prev = 1'b0;
  logic              m_used = 1'b0;
  logic [PW_W-1:0]   m_pw = '0;
  logic [ADDR_W-1:0] m_max = NATIVE;
  logic [ADDR_W-1:0] m_saved = NATIVE;

  task automatic check(input logic cond, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // irregular back-pressure
  logic [7:0] lfsr = 8'hA5;
  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rsp_ready = lfsr[0] | lfsr[2];
  end

  // monitor: scoreboard compare and hold check (R12)
  logic              hold_seen = 1'b0;
  logic [7:0]        hold_st;
  logic [ADDR_W-1:0] hold_ad;
  always @(negedge clk) begin
    if (rst_n && !hard_rst) begin
      if (hold_seen) begin
        check(rsp_valid && rsp_status == hold_st && rsp_addr == hold_ad,
              "R12", "held result changed", {rsp_status, 24'(rsp_addr)},
              {hold_st, 24'(hold_ad)});
      end
      hold_seen = rsp_valid && !rsp_ready;
      hold_st   = rsp_status;
      hold_ad   = rsp_addr;
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R5", "unexpected result", 32'(rsp_status), 32'h0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(rsp_status == e.st, e.tag, "status", 32'(rsp_status), 32'(e.st));
          check(rsp_error == e.er, e.tag, "error", 32'(rsp_error), 32'(e.er));
          check(rsp_addr == e.ad, e.tag, "rsp_addr", 32'(rsp_addr), 32'(e.ad));
          check(max_addr == e.mx, e.tag, "max_addr", 32'(max_addr), 32'(e.mx));
          check(lock_state == e.lk, e.tag, "lock_state", 32'(lock_state), 32'(e.lk));
        end
      end
    end
  end

  task automatic send(input logic [7:0] code, input logic [7:0] feat,
                      input logic [ADDR_W-1:0] addr, input logic keep,
                      input logic [PW_W-1:0] pw, input string tag);
    exp_t e;
    logic resp, ok;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_code = code; cmd_feature = feat;
    cmd_addr = addr; cmd_keep = keep; cmd_pw = pw;
    @(posedge clk);
    #1 cmd_valid = 1'b0;
    resp = 1'b0; ok = 1'b0;
    if (code == 8'hF8) begin
      resp = 1'b1; ok = 1'b1;
    end else if (code == 8'hF9) begin
      resp = 1'b1;
      case (feat)
        8'h00: if (m_lock == 2'd0 && m_prev && addr <= NATIVE && !(keep && m_used)) begin
                 ok = 1'b1; m_max = addr;
                 if (keep) begin m_used = 1'b1; m_saved = addr; end
               end
        8'h01: if (m_lock == 2'd0) begin ok = 1'b1; m_pw = pw; end
        8'h02: if (m_lock == 2'd0) begin ok = 1'b1; m_lock = 2'd1; end
        8'h03: if (m_lock == 2'd1 && pw == m_pw) begin ok = 1'b1; m_lock = 2'd0; end
        8'h04: if (m_lock != 2'd2) begin ok = 1'b1; m_lock = 2'd2; end
        default: ok = 1'b0;
      endcase
    end
    m_prev = (code == 8'hF8);
    if (resp) begin
      e.st = ok ? 8'h50 : 8'h51;
      e.er = ok ? 8'h00 : 8'h04;
      e.ad = (code == 8'hF8) ? NATIVE : m_max;
      e.mx = m_max;
      e.lk = m_lock;
      e.tag = tag;
      exp_q.push_back(e);
    end
  endtask

  task automatic drain();
    @(negedge clk);
    while (exp_q.size() != 0 || rsp_valid) @(negedge clk);
  endtask

  task automatic pulse_hard_reset();
    drain();
    hard_rst = 1'b1;
    @(posedge clk);
    #1 hard_rst = 1'b0;
    m_lock = 2'd0; m_prev = 1'b0; m_used = 1'b0; m_max = m_saved;
    @(negedge clk);
    check(max_addr == m_saved, "R7", "limit after hard reset", 32'(max_addr), 32'(m_saved));
    check(lock_state == 2'd0, "R7", "lock after hard reset", 32'(lock_state), 32'd0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(max_addr == NATIVE, "R1", "max_addr", 32'(max_addr), 32'(NATIVE));
    check(lock_state == 2'd0, "R1", "lock_state", 32'(lock_state), 32'd0);
    check(!rsp_valid, "R1", "rsp_valid", 32'(rsp_valid), 32'd0);
    check(cmd_ready, "R1", "cmd_ready", 32'(cmd_ready), 32'd1);

    send(8'hF9, 8'h00, 28'd1000, 1'b0, '0, "R3");        // no prior query
    send(8'hF8, 8'h00, '0, 1'b0, '0, "R2");
    send(8'hF9, 8'h00, 28'd1000, 1'b0, '0, "R4");
    send(8'hF9, 8'h00, 28'd2000, 1'b0, '0, "R3");        // query consumed
    send(8'hF8, 8'h00, '0, 1'b0, '0, "R2");
    send(8'hF9, 8'h00, NATIVE + 28'd1, 1'b0, '0, "R8");  // above native
    send(8'hF8, 8'h00, '0, 1'b0, '0, "R2");
    send(8'hF9, 8'h00, NATIVE, 1'b0, '0, "R8");          // equal to native
    // R5: other code, no result, clears the query
    send(8'hF8, 8'h00, '0, 1'b0, '0, "R2");
    drain();
    send(8'h20, 8'h00, 28'd3, 1'b1, '0, "R5");
    repeat (3) @(negedge clk);
    check(!rsp_valid, "R5", "no result for other code", 32'(rsp_valid), 32'd0);
    check(max_addr == m_max, "R5", "limit unchanged", 32'(max_addr), 32'(m_max));
    send(8'hF9, 8'h00, 28'd1500, 1'b0, '0, "R5");
    // R6 persistent once
    send(8'hF8, 8'h00, '0, 1'b0, '0, "R2");
    send(8'hF9, 8'h00, 28'd5000, 1'b1, '0, "R6");
    send(8'hF8, 8'h00, '0, 1'b0, '0, "R2");
    send(8'hF9, 8'h00, 28'd6000, 1'b1, '0, "R6");
    send(8'hF8, 8'h00, '0, 1'b0, '0, "R2");
    send(8'hF9, 8'h00, 28'd7000, 1'b0, '0, "R6");
    // R7 hard reset restores persisted limit and allowance
    send(8'hF8, 8'h00, '0, 1'b0, '0, "R2");
    pulse_hard_reset();
    send(8'hF9, 8'h00, 28'd100, 1'b0, '0, "R7");         // query forgotten
    send(8'hF8, 8'h00, '0, 1'b0, '0, "R2");
    send(8'hF9, 8'h00, 28'd4000, 1'b1, '0, "R7");
    // R10 password, lock, unlock
    send(8'hF9, 8'h01, '0, 1'b0, 16'hBEEF, "R10");
    send(8'hF9, 8'h03, '0, 1'b0, 16'hBEEF, "R10");       // not locked
    send(8'hF9, 8'h02, '0, 1'b0, '0, "R10");
    send(8'hF9, 8'h02, '0, 1'b0, '0, "R10");             // already locked
    send(8'hF9, 8'h01, '0, 1'b0, 16'h1111, "R10");       // locked
    send(8'hF8, 8'h00, '0, 1'b0, '0, "R2");
    send(8'hF9, 8'h00, 28'd300, 1'b0, '0, "R9");
    send(8'hF9, 8'h03, '0, 1'b0, 16'hBEEE, "R10");       // wrong password
    send(8'hF9, 8'h03, '0, 1'b0, 16'hBEEF, "R10");
    send(8'hF8, 8'h00, '0, 1'b0, '0, "R2");
    send(8'hF9, 8'h00, 28'd350, 1'b0, '0, "R4");
    // R11 freeze
    send(8'hF9, 8'h07, '0, 1'b0, '0, "R11");             // unknown feature
    send(8'hF9, 8'h02, '0, 1'b0, '0, "R10");
    send(8'hF9, 8'h04, '0, 1'b0, '0, "R11");             // locked -> frozen
    send(8'hF9, 8'h03, '0, 1'b0, 16'hBEEF, "R11");
    send(8'hF9, 8'h04, '0, 1'b0, '0, "R11");
    send(8'hF8, 8'h00, '0, 1'b0, '0, "R2");
    send(8'hF9, 8'h00, 28'd200, 1'b0, '0, "R9");
    send(8'hF9, 8'h01, '0, 1'b0, 16'h2222, "R11");
    pulse_hard_reset();
    send(8'hF9, 8'h04, '0, 1'b0, '0, "R11");             // open -> frozen
    send(8'hF9, 8'h02, '0, 1'b0, '0, "R11");
    pulse_hard_reset();
    send(8'hF8, 8'h00, '0, 1'b0, '0, "R2");
    send(8'hF9, 8'h00, 28'd0, 1'b0, '0, "R4");
    drain();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule